// File: doc/BRIEF.md
# Priority-Score Block Refine Controller

This controller decides, block by block, how much of a square macroblock held in a local canvas buffer must be fetched from the source and how much can be filled in by interpolation. The macroblock edge is 2^LOG_EDGE+1 pixels (17 by 17 by default) of 8-bit grayscale. A start pulse seeds a coarse uniform grid of sub-blocks with span 2^INIT_LOG. Each queued sub-block is identified by a span exponent and the coordinate of its upper-left pixel. The controller reads the block's four corner pixels through the canvas read port and forms a priority score. The score is the block's area in pixels, (span+1)^2, times the spread between the largest and smallest corner value.

If the score is above the threshold, the block is sent to the address generator as a refine descriptor, and its four half-span children are queued. Otherwise the block is pushed to the interpolation FIFO as an interpolation descriptor. All blocks of one span are handled before any block of the next finer span. When no blocks remain, a done flag is raised. Fetching samples, the memory protocol and the interpolation arithmetic are outside this block.

Top module: `rcp_refine_ctrl`

## Requirements
- R1: After reset, done is low and ref_vld, itp_vld and cv_rd_en are all low.
- R2: A start pulse while idle captures thr, clears done, and queues the seed grid in row-major order, x varying fastest. The seed grid has span 2^INIT_LOG, with anchors at multiples of that span.
- R3: Each block issues exactly four canvas reads, in the order (x,y), (x+s,y), (x,y+s), (x+s,y+s), where s is the span. cv_rd_data is taken one cycle after each read.
- R4: The score is (s+1)^2 times (max corner - min corner). A block is refined only when its score is strictly greater than the captured threshold; a score equal to the threshold goes to interpolation.
- R5: Every evaluated block yields exactly one descriptor on either the refine output or the interpolation output, never both in one cycle. The lvl field of a descriptor is log2 of its span.
- R6: A refined block queues four children of half span, in the order top-left, top-right, bottom-left, bottom-right. No block of a finer span is evaluated before every block of the coarser span has been handled.
- R7: A block whose span is 2^MIN_LOG (2 by default) is never refined, whatever its score.
- R8: done rises only after every queued block has been handled. It then stays high with no reads or descriptors until the next start, which clears it.
- R9: A start pulse or a threshold change while a run is in progress has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| thr | input | SCORE_W | Refine threshold, captured at start |
| cv_rd_en | output | 1 | Canvas read strobe |
| cv_rd_x | output | COORD_W | Canvas read column |
| cv_rd_y | output | COORD_W | Canvas read row |
| cv_rd_data | input | PIX_W | Canvas read data, one cycle after the strobe |
| ref_vld | output | 1 | Refine descriptor valid |
| ref_lvl | output | LVL_W | Refine descriptor span exponent |
| ref_x | output | COORD_W | Refine descriptor anchor column |
| ref_y | output | COORD_W | Refine descriptor anchor row |
| itp_vld | output | 1 | Interpolation FIFO push |
| itp_lvl | output | LVL_W | Interpolation descriptor span exponent |
| itp_x | output | COORD_W | Interpolation descriptor anchor column |
| itp_y | output | COORD_W | Interpolation descriptor anchor row |
| done | output | 1 | Run complete |

## Verification
The bench targets the score boundary: a single corner offset of 10 on the first seed block gives a score of exactly 810. A controller that compares with >= instead of > would refine that block at a threshold of 810.

A threshold of zero over a busy canvas drives refinement down to the smallest span. A design that ignores the minimum-span rule would emit refine descriptors of span 2. A design whose queue leaked across levels would emit children before their coarser siblings, and the per-clock comparison against the reference event order would flag it. A start pulse with a changed threshold in mid-run checks that a design does not re-seed or switch thresholds during a run.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED,
    ST_POP,
    ST_WAIT,
    ST_KIDS
  } ctl_state_t;

  // Pixel count of a block whose edge spans 2^span_log steps.
  function automatic int unsigned blk_area(input int unsigned span_log);
    int unsigned side;
    side = (32'd1 << span_log) + 32'd1;
    return side * side;
  endfunction

  function automatic int unsigned blk_score(input int unsigned span_log,
                                            input int unsigned spread);
    return blk_area(span_log) * spread;
  endfunction

  function automatic logic refine_needed(input int unsigned score,
                                         input int unsigned limit,
                                         input int unsigned span_log,
                                         input int unsigned min_log);
    return (span_log > min_log) && (score > limit);
  endfunction

endpackage

// File: rtl/rcp_desc_fifo.sv
module rcp_desc_fifo #(
  parameter int W     = 13,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == (AW+1)'(DEPTH));
  assign dout  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + AW'(1);
      if (pop)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + AW'(1);
      cnt_q <= cnt_q + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full) else $error("block queue overflow");

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty) else $error("block queue underflow");

endmodule

// File: rtl/rcp_corner_gather.sv
module rcp_corner_gather #(
  parameter int PIX_W   = 8,
  parameter int COORD_W = 5,
  parameter int LVL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [LVL_W-1:0]   go_lvl,
  input  logic [COORD_W-1:0] go_x,
  input  logic [COORD_W-1:0] go_y,
  output logic               rd_en,
  output logic [COORD_W-1:0] rd_x,
  output logic [COORD_W-1:0] rd_y,
  input  logic [PIX_W-1:0]   rd_data,
  output logic               rng_vld,
  output logic [PIX_W-1:0]   rng
);
  logic [LVL_W-1:0]   lvl_q;
  logic [COORD_W-1:0] x_q, y_q, span;
  logic [1:0]         k_q;
  logic               act_q, pend_q, first_q, last_q;
  logic [PIX_W-1:0]   mn_q, mx_q, mn_n, mx_n;

  assign span  = COORD_W'(1) << lvl_q;
  assign rd_en = act_q;
  // corner index bit 0 selects right column, bit 1 selects lower row (R3)
  assign rd_x  = x_q + (k_q[0] ? span : '0);
  assign rd_y  = y_q + (k_q[1] ? span : '0);

  assign mn_n    = (rd_data < mn_q) ? rd_data : mn_q;
  assign mx_n    = (rd_data > mx_q) ? rd_data : mx_q;
  assign rng_vld = pend_q && last_q;
  assign rng     = mx_n - mn_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      x_q     <= '0;
      y_q     <= '0;
      k_q     <= '0;
      act_q   <= 1'b0;
      pend_q  <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      mn_q    <= '0;
      mx_q    <= '0;
    end else begin
      pend_q  <= rd_en;
      first_q <= rd_en && (k_q == 2'd0);
      last_q  <= rd_en && (k_q == 2'd3);
      if (go) begin
        lvl_q <= go_lvl;
        x_q   <= go_x;
        y_q   <= go_y;
        k_q   <= '0;
        act_q <= 1'b1;
      end else if (act_q) begin
        k_q <= k_q + 2'd1;
        if (k_q == 2'd3) act_q <= 1'b0;
      end
      if (pend_q) begin
        mn_q <= first_q ? rd_data : mn_n;
        mx_q <= first_q ? rd_data : mx_n;
      end
    end
  end

  p_go_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !act_q) else $error("corner fetch restarted while busy");

  p_range_after_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rng_vld |-> !rd_en) else $error("range reported before reads finished");

  p_four_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> rd_en) else $error("read did not follow fetch request");

endmodule

// File: rtl/rcp_refine_ctrl.sv
module rcp_refine_ctrl #(
  parameter int PIX_W    = 8,
  parameter int LOG_EDGE = 4,
  parameter int INIT_LOG = 3,
  parameter int MIN_LOG  = 1,
  localparam int COORD_W = LOG_EDGE + 1,
  localparam int LVL_W   = $clog2(LOG_EDGE + 1),
  localparam int SCORE_W = 2 * (LOG_EDGE + 1) + PIX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SCORE_W-1:0] thr,
  output logic               cv_rd_en,
  output logic [COORD_W-1:0] cv_rd_x,
  output logic [COORD_W-1:0] cv_rd_y,
  input  logic [PIX_W-1:0]   cv_rd_data,
  output logic               ref_vld,
  output logic [LVL_W-1:0]   ref_lvl,
  output logic [COORD_W-1:0] ref_x,
  output logic [COORD_W-1:0] ref_y,
  output logic               itp_vld,
  output logic [LVL_W-1:0]   itp_lvl,
  output logic [COORD_W-1:0] itp_x,
  output logic [COORD_W-1:0] itp_y,
  output logic               done
);
  import rcp_pkg::*;

  localparam int DESC_W = LVL_W + 2 * COORD_W;
  localparam int GRID   = 1 << (LOG_EDGE - INIT_LOG);
  localparam int GW     = $clog2(GRID) + 1;
  localparam int QDEPTH = 1 << (2 * (LOG_EDGE - MIN_LOG));

  ctl_state_t         state_q;
  logic [SCORE_W-1:0] thr_q;
  logic [GW-1:0]      gi_q, gj_q;
  logic [LVL_W-1:0]   cur_lvl, last_lvl_q;
  logic [COORD_W-1:0] cur_x, cur_y, half;
  logic [1:0]         kid_q;
  logic               done_q;

  // Named internal events for the checks
  logic               q_push, q_pop, q_empty, q_full;
  logic [DESC_W-1:0]  q_din, q_dout;
  logic [LVL_W-1:0]   head_lvl;
  logic [COORD_W-1:0] head_x, head_y;
  logic               fetch_go, rng_vld, decide_ref;
  logic [PIX_W-1:0]   rng;
  logic [SCORE_W-1:0] score;

  assign head_lvl = q_dout[DESC_W-1 -: LVL_W];
  assign head_x   = q_dout[2*COORD_W-1 -: COORD_W];
  assign head_y   = q_dout[COORD_W-1:0];

  assign half = COORD_W'(1) << (cur_lvl - LVL_W'(1));

  always_comb begin
    q_push = 1'b0;
    q_din  = '0;
    if (state_q == ST_SEED) begin
      q_push = 1'b1;
      q_din  = {LVL_W'(INIT_LOG),
                COORD_W'(gi_q) << INIT_LOG,
                COORD_W'(gj_q) << INIT_LOG};
    end else if (state_q == ST_KIDS) begin
      q_push = 1'b1;
      q_din  = {cur_lvl - LVL_W'(1),
                cur_x + (kid_q[0] ? half : '0),
                cur_y + (kid_q[1] ? half : '0)};
    end
  end

  assign q_pop    = (state_q == ST_POP) && !q_empty;
  assign fetch_go = q_pop;

  assign score      = SCORE_W'(blk_score(32'(cur_lvl), 32'(rng)));
  assign decide_ref = refine_needed(32'(score), 32'(thr_q),
                                    32'(cur_lvl), 32'(MIN_LOG));

  rcp_desc_fifo #(.W(DESC_W), .DEPTH(QDEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .din   (q_din),
    .pop   (q_pop),
    .dout  (q_dout),
    .empty (q_empty),
    .full  (q_full)
  );

  rcp_corner_gather #(.PIX_W(PIX_W), .COORD_W(COORD_W), .LVL_W(LVL_W)) u_gather (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (fetch_go),
    .go_lvl  (head_lvl),
    .go_x    (head_x),
    .go_y    (head_y),
    .rd_en   (cv_rd_en),
    .rd_x    (cv_rd_x),
    .rd_y    (cv_rd_y),
    .rd_data (cv_rd_data),
    .rng_vld (rng_vld),
    .rng     (rng)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      thr_q      <= '0;
      gi_q       <= '0;
      gj_q       <= '0;
      cur_lvl    <= '0;
      cur_x      <= '0;
      cur_y      <= '0;
      kid_q      <= '0;
      last_lvl_q <= '0;
      done_q     <= 1'b0;
      ref_vld    <= 1'b0;
      ref_lvl    <= '0;
      ref_x      <= '0;
      ref_y      <= '0;
      itp_vld    <= 1'b0;
      itp_lvl    <= '0;
      itp_x      <= '0;
      itp_y      <= '0;
    end else begin
      ref_vld <= 1'b0;
      itp_vld <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          thr_q      <= thr;
          done_q     <= 1'b0;
          gi_q       <= '0;
          gj_q       <= '0;
          last_lvl_q <= LVL_W'(INIT_LOG);
          state_q    <= ST_SEED;
        end
        ST_SEED: begin
          if (gi_q == GW'(GRID - 1)) begin
            gi_q <= '0;
            if (gj_q == GW'(GRID - 1)) state_q <= ST_POP;
            else gj_q <= gj_q + GW'(1);
          end else begin
            gi_q <= gi_q + GW'(1);
          end
        end
        ST_POP: begin
          if (q_empty) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cur_lvl    <= head_lvl;
            cur_x      <= head_x;
            cur_y      <= head_y;
            last_lvl_q <= head_lvl;
            state_q    <= ST_WAIT;
          end
        end
        ST_WAIT: if (rng_vld) begin
          if (decide_ref) begin
            ref_vld <= 1'b1;
            ref_lvl <= cur_lvl;
            ref_x   <= cur_x;
            ref_y   <= cur_y;
            kid_q   <= '0;
            state_q <= ST_KIDS;
          end else begin
            itp_vld <= 1'b1;
            itp_lvl <= cur_lvl;
            itp_x   <= cur_x;
            itp_y   <= cur_y;
            state_q <= ST_POP;
          end
        end
        ST_KIDS: begin
          kid_q <= kid_q + 2'd1;
          if (kid_q == 2'd3) state_q <= ST_POP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done = done_q;

  p_one_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_vld && itp_vld)) else $error("refine and interpolate in one cycle");

  p_min_span_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_vld |-> (ref_lvl > LVL_W'(MIN_LOG))) else $error("smallest span refined");

  p_level_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |-> (head_lvl <= last_lvl_q)) else $error("coarser block after finer one");

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!cv_rd_en && !ref_vld && !itp_vld)) else $error("activity after done");

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start) |=> done_q) else $error("done dropped without start");

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state_q != ST_IDLE) |=> $stable(thr_q)) else $error("threshold changed mid-run");

endmodule

// File: tb/rcp_refine_ctrl_bench.sv
`timescale 1ns/1ps
module rcp_refine_ctrl_bench;
  localparam int EDGE = 17, INIT_LOG = 3, MIN_LOG = 1;
  localparam int COORD_W = 5, LVL_W = 3, SCORE_W = 18, PIX_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [SCORE_W-1:0] thr_in = '0;
  logic cv_rd_en, ref_vld, itp_vld, done;
  logic [COORD_W-1:0] cv_rd_x, cv_rd_y, ref_x, ref_y, itp_x, itp_y;
  logic [LVL_W-1:0] ref_lvl, itp_lvl;
  logic [PIX_W-1:0] cv_rd_data = '0;

  logic [7:0] canvas [0:EDGE-1][0:EDGE-1];
  int exp_ev[$];
  int exp_rd[$];
  int n_chk = 0, n_fail = 0, cycles = 0;
  bit mon_on = 0;
  int first_ev = -1, ref_min_cnt = 0;

  always #2.5 clk = ~clk;

  rcp_refine_ctrl u_rcp_refine_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .thr(thr_in),
    .cv_rd_en(cv_rd_en), .cv_rd_x(cv_rd_x), .cv_rd_y(cv_rd_y), .cv_rd_data(cv_rd_data),
    .ref_vld(ref_vld), .ref_lvl(ref_lvl), .ref_x(ref_x), .ref_y(ref_y),
    .itp_vld(itp_vld), .itp_lvl(itp_lvl), .itp_x(itp_x), .itp_y(itp_y),
    .done(done));

  // canvas with one cycle read latency
  always @(posedge clk) if (cv_rd_en) cv_rd_data <= canvas[cv_rd_y][cv_rd_x];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pk(input int l, input int x, input int y);
    return (l << 16) | (x << 8) | y;
  endfunction

  task automatic fill(input int kind);
    for (int y = 0; y < EDGE; y++)
      for (int x = 0; x < EDGE; x++)
        case (kind)
          0: canvas[y][x] = 8'd100;
          1: canvas[y][x] = 8'((x * 37 + y * 91 + x * y * 13) % 256);
          2: canvas[y][x] = 8'(x * 15);
          default: canvas[y][x] = (x == 0 && y == 0) ? 8'd10 : 8'd0;
        endcase
  endtask

  // Reference: breadth-first walk with a plain queue
  task automatic build_model(input int thr);
    int q[$];
    int d, l, x, y, s, h, mx, mn, sc;
    int c[4];
    exp_ev.delete();
    exp_rd.delete();
    for (int gy = 0; gy < (16 >> INIT_LOG); gy++)
      for (int gx = 0; gx < (16 >> INIT_LOG); gx++)
        q.push_back(pk(INIT_LOG, gx << INIT_LOG, gy << INIT_LOG));
    while (q.size() > 0) begin
      d = q.pop_front();
      l = d >> 16; x = (d >> 8) & 255; y = d & 255; s = 1 << l;
      c[0] = canvas[y][x];     c[1] = canvas[y][x+s];
      c[2] = canvas[y+s][x];   c[3] = canvas[y+s][x+s];
      exp_rd.push_back((x << 8) | y);
      exp_rd.push_back(((x + s) << 8) | y);
      exp_rd.push_back((x << 8) | (y + s));
      exp_rd.push_back(((x + s) << 8) | (y + s));
      mx = c[0]; mn = c[0];
      for (int i = 1; i < 4; i++) begin
        if (c[i] > mx) mx = c[i];
        if (c[i] < mn) mn = c[i];
      end
      sc = (s + 1) * (s + 1) * (mx - mn);
      if (l > MIN_LOG && sc > thr) begin
        h = s / 2;
        exp_ev.push_back((1 << 24) | d);
        q.push_back(pk(l - 1, x, y));
        q.push_back(pk(l - 1, x + h, y));
        q.push_back(pk(l - 1, x, y + h));
        q.push_back(pk(l - 1, x + h, y + h));
      end else begin
        exp_ev.push_back(d);
      end
    end
  endtask

  // Per-clock comparison against the reference streams (R3, R5, R6)
  always @(negedge clk) if (mon_on) begin
    int a, e;
    if (cv_rd_en) begin
      a = (int'(cv_rd_x) << 8) | int'(cv_rd_y);
      e = (exp_rd.size() > 0) ? exp_rd.pop_front() : -1;
      chk(a == e, "R3 corner read", a, e);
    end
    if (ref_vld || itp_vld) begin
      chk(!(ref_vld && itp_vld), "R5 single output", 1, 0);
      a = ref_vld ? ((1 << 24) | pk(int'(ref_lvl), int'(ref_x), int'(ref_y)))
                  : pk(int'(itp_lvl), int'(itp_x), int'(itp_y));
      if (first_ev < 0) first_ev = a;
      if (ref_vld && ref_lvl == LVL_W'(MIN_LOG)) ref_min_cnt++;
      e = (exp_ev.size() > 0) ? exp_ev.pop_front() : -1;
      chk(a == e, "R6 descriptor order", a, e);
    end
  end

  task automatic run_case(input int kind, input int thr, input bit poke);
    bit got;
    fill(kind);
    build_model(thr);
    first_ev = -1;
    ref_min_cnt = 0;
    @(negedge clk); start = 1'b1; thr_in = SCORE_W'(thr);
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, "R8 done cleared by start", int'(done), 0);
    got = 0;
    for (int i = 0; i < 20000 && !got; i++) begin
      @(negedge clk);
      if (done) got = 1;
      if (poke && i == 30) begin start = 1'b1; thr_in = '0; end  // R9
      if (poke && i == 31) start = 1'b0;
    end
    chk(got, "R8 done reached", int'(got), 1);
    chk(exp_ev.size() == 0, "R8 all descriptors before done", exp_ev.size(), 0);
    chk(exp_rd.size() == 0, "R8 all reads before done", exp_rd.size(), 0);
    repeat (3) @(negedge clk);
    chk(done && !ref_vld && !itp_vld && !cv_rd_en, "R8 done held quiet", int'(done), 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !ref_vld && !itp_vld && !cv_rd_en, "R1 reset state",
        {done, ref_vld, itp_vld, cv_rd_en}, 0);
    mon_on = 1;
    // R2: flat canvas, seed grid order with no refinement (R4 zero spread)
    run_case(0, 150, 0);
    chk(first_ev == pk(INIT_LOG, 0, 0), "R2 first seed block", first_ev, pk(INIT_LOG, 0, 0));
    run_case(1, 150, 0);    // R5 R6 mixed decisions
    run_case(1, 1800, 0);
    // R7: threshold zero forces refinement down to the smallest span
    run_case(1, 0, 0);
    chk(ref_min_cnt == 0, "R7 smallest span never refined", ref_min_cnt, 0);
    run_case(1, 262143, 0); // R4 nothing exceeds the largest threshold
    // R4 boundary: first block score is exactly 810
    run_case(3, 810, 0);
    chk(first_ev == pk(3, 0, 0), "R4 equal score interpolated", first_ev, pk(3, 0, 0));
    run_case(3, 809, 0);
    chk(first_ev == ((1 << 24) | pk(3, 0, 0)), "R4 score above refined",
        first_ev, (1 << 24) | pk(3, 0, 0));
    run_case(2, 150, 1);    // R9 start and threshold change mid-run ignored
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule